// File: doc/BRIEF.md
# Overlapping-Window Register File

This block holds the integer registers of a load-store processor core whose call convention rotates a register window. Every instruction names 32 architectural registers with a 5-bit number. Numbers 0 to 7 are global registers, the same storage for every window. Numbers 8 to 31 are reached through a current window pointer. Number 0 always reads as zero.

Each window owns 16 physical registers: 8 outgoing registers (numbers 8 to 15) and 8 private locals (numbers 16 to 23). Its 8 incoming registers (numbers 24 to 31) are physically the outgoing registers of the window one step higher. A caller therefore places arguments in its outgoing registers, issues a save, and the callee finds them in its incoming registers. A save moves the pointer down by one and a restore moves it up by one, both wrapping around the window count. A per-window invalid mask blocks entry into marked windows and raises a trap flag, so that software can spill or fill memory.

Reads are combinational, with two read ports and one write port. The ports are plain register-file ports rather than streams: there is no back-pressure, and every request is served in the cycle it is presented. A save or restore takes effect at the clock edge. A blocked request leaves the pointer unchanged, and its trap flag is high for the following cycle.

Top module: `win_regfile`

## Requirements
- R1: Registers 1 to 7 are global. A value written to one of them reads back unchanged whatever the window pointer is when it is read.
- R2: Register 0 reads as zero on both read ports. A write to it has no effect, both in the cycle of the write and afterwards.
- R3: For a window w, the outgoing register 8+i (i = 0..7) is the same storage as the incoming register 24+i of window w-1 (mod NWIN). Seen from the other side, the incoming register 24+i of window w is the outgoing register 8+i of window (w+1) mod NWIN. This wrap also holds at window NWIN-1.
- R4: Reset sets the window pointer to 0, clears the invalid mask and every register, and drops both trap flags. Locals 16 to 23 are private to each window: a write to a local in one window leaves the locals of every other window unchanged.
- R5: A save that is not blocked sets the pointer to (cwp-1) mod NWIN at the next edge. A restore that is not blocked sets it to (cwp+1) mod NWIN. When save and restore are both high, only the save acts. The pointer never leaves 0..NWIN-1.
- R6: The invalid mask has bit k for window k and is loaded from wim_wdata when wim_we is high. A save whose target window has its mask bit set leaves the pointer unchanged, and ovf_trap is high for the next cycle only. A restore blocked in the same way raises unf_trap instead. The two flags are never high together.
- R7: A read returns the latest value written to the physical register it maps to. A write in the same cycle to that physical register counts as the latest value, so its data is returned directly (write-first).
- R8: A register write in the same cycle as a save or restore is mapped with the pointer value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_addr | input | 5 | Architectural register number, read port A |
| rd_b_addr | input | 5 | Architectural register number, read port B |
| rd_a_data | output | DW | Read data, port A (combinational) |
| rd_b_data | output | DW | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural register number to write |
| wr_data | input | DW | Write data |
| save_req | input | 1 | Move to the next lower window |
| restore_req | input | 1 | Move to the next higher window |
| wim_we | input | 1 | Load the invalid mask |
| wim_wdata | input | NWIN | New invalid mask value |
| cwp_o | output | 5 | Current window pointer |
| ovf_trap | output | 1 | Save was blocked by the mask (one cycle) |
| unf_trap | output | 1 | Restore was blocked by the mask (one cycle) |

## Verification
The bench sends writes to outgoing registers together with a save, then reads the matching incoming registers in the new window. A design that mapped the write through the new pointer, or that paired the overlap the wrong way, returns a different value there. It forces the pointer across the wrap between window 0 and window NWIN-1 and masks the targets of both save and restore. A wrong modulo or a missing hold would leave a pointer that strays or moves on a trap. It also reads registers in the same cycle they are written, and writes register 0, which catches a missing bypass or a zero register that can be written.

// File: rtl/winrf_pkg.sv
package winrf_pkg;
  localparam int ARCH_W   = 5;
  localparam int GLOBALS  = 8;
  localparam int WIN_REGS = 16;

  typedef logic [ARCH_W-1:0] arch_t;

  typedef enum logic [1:0] {
    WIN_HOLD    = 2'd0,
    WIN_SAVE    = 2'd1,
    WIN_RESTORE = 2'd2
  } win_op_e;
endpackage

// File: rtl/winrf_map.sv
module winrf_map
  import winrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int PW   = 8
) (
  input  arch_t         cwp,
  input  arch_t         arch,
  output logic [PW-1:0] phys
);
  localparam int unsigned SPAN = NWIN * WIN_REGS;

  int unsigned lin;

  always_comb begin
    lin  = '0;
    phys = '0;
    if (int'(arch) < GLOBALS) begin
      phys = PW'(arch);
    end else begin
      lin = 32'(cwp) * WIN_REGS + 32'(arch) - GLOBALS;
      if (lin >= SPAN) lin = lin - SPAN;
      phys = PW'(lin + GLOBALS);
    end
  end
endmodule

// File: rtl/winrf_ctrl.sv
module winrf_ctrl
  import winrf_pkg::*;
#(
  parameter int NWIN = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            wim_we,
  input  logic [NWIN-1:0] wim_wdata,
  output arch_t           cwp,
  output logic            ovf_trap,
  output logic            unf_trap
);
  localparam arch_t LAST = arch_t'(NWIN - 1);

  logic [NWIN-1:0] wim;
  logic [31:0]     wim_ext;
  arch_t           down_w, up_w, tgt;
  win_op_e         op;
  logic            blocked;

  always_comb begin
    down_w  = (cwp == '0)   ? LAST : cwp - arch_t'(1);
    up_w    = (cwp == LAST) ? '0   : cwp + arch_t'(1);
    if (save_req)         op = WIN_SAVE;
    else if (restore_req) op = WIN_RESTORE;
    else                  op = WIN_HOLD;
    tgt     = (op == WIN_SAVE) ? down_w : up_w;
    wim_ext = 32'(wim);
    blocked = wim_ext[tgt];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cwp      <= '0;
      wim      <= '0;
      ovf_trap <= 1'b0;
      unf_trap <= 1'b0;
    end else begin
      ovf_trap <= (op == WIN_SAVE)    &&  blocked;
      unf_trap <= (op == WIN_RESTORE) &&  blocked;
      if (op != WIN_HOLD && !blocked) cwp <= tgt;
      if (wim_we) wim <= wim_wdata;
    end
  end

  // R5
  cwp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cwp) < NWIN);

  // R5
  save_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    save_req |=> (ovf_trap || cwp != $past(cwp)));

  // R6
  trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_trap || unf_trap) |-> cwp == $past(cwp));

  // R6
  trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ovf_trap, unf_trap}));
endmodule

// File: rtl/winrf_bank.sv
module winrf_bank #(
  parameter int DW    = 32,
  parameter int NPHYS = 136,
  parameter int PW    = 8,
  parameter int NRD   = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [PW-1:0]           wr_idx,
  input  logic [DW-1:0]           wr_data,
  input  logic [NRD-1:0][PW-1:0]  rd_idx,
  output logic [NRD-1:0][DW-1:0]  rd_data
);
  logic [DW-1:0] mem [NPHYS];
  logic          wr_live;

  assign wr_live = wr_en && (wr_idx != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
    end else if (wr_live) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      if (rd_idx[p] == '0)                   rd_data[p] = '0;
      else if (wr_live && wr_idx == rd_idx[p]) rd_data[p] = wr_data;
      else                                   rd_data[p] = mem[rd_idx[p]];
    end

    // R7
    hold_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(wr_en) && $past(wr_idx) != '0 &&
       rd_idx[p] == $past(wr_idx) && !(wr_en && wr_idx == rd_idx[p]))
      |-> rd_data[p] == $past(wr_data));
  end
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import winrf_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [4:0]      rd_a_addr,
  input  logic [4:0]      rd_b_addr,
  output logic [DW-1:0]   rd_a_data,
  output logic [DW-1:0]   rd_b_data,
  input  logic            wr_en,
  input  logic [4:0]      wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            wim_we,
  input  logic [NWIN-1:0] wim_wdata,
  output logic [4:0]      cwp_o,
  output logic            ovf_trap,
  output logic            unf_trap
);
  localparam int NPHYS = GLOBALS + NWIN * WIN_REGS;
  localparam int PW    = $clog2(NPHYS);
  localparam int NMAP  = 3;

  arch_t                    cwp;
  arch_t   [NMAP-1:0]       map_in;
  logic    [NMAP-1:0][PW-1:0] map_out;
  logic    [1:0][PW-1:0]    rd_idx;
  logic    [1:0][DW-1:0]    rd_data;

  assign map_in[0] = rd_a_addr;
  assign map_in[1] = rd_b_addr;
  assign map_in[2] = wr_addr;

  winrf_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .save_req   (save_req),
    .restore_req(restore_req),
    .wim_we     (wim_we),
    .wim_wdata  (wim_wdata),
    .cwp        (cwp),
    .ovf_trap   (ovf_trap),
    .unf_trap   (unf_trap)
  );

  for (genvar m = 0; m < NMAP; m++) begin : g_map
    winrf_map #(.NWIN(NWIN), .PW(PW)) u_map (
      .cwp (cwp),
      .arch(map_in[m]),
      .phys(map_out[m])
    );
  end

  assign rd_idx[0] = map_out[0];
  assign rd_idx[1] = map_out[1];

  winrf_bank #(.DW(DW), .NPHYS(NPHYS), .PW(PW), .NRD(2)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (map_out[2]),
    .wr_data(wr_data),
    .rd_idx (rd_idx),
    .rd_data(rd_data)
  );

  assign rd_a_data = rd_data[0];
  assign rd_b_data = rd_data[1];
  assign cwp_o     = cwp;

  // R2
  zero_rda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == 5'd0) |-> (rd_a_data == '0));

  // R2
  zero_rdb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_addr == 5'd0) |-> (rd_b_data == '0));
endmodule

// File: tb/win_regfile_test.sv
module win_regfile_test;
  localparam int NWIN  = 8;
  localparam int DW    = 32;
  localparam int NPHYS = 8 + NWIN * 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [4:0]      rd_a_addr = '0, rd_b_addr = '0, wr_addr = '0;
  logic [DW-1:0]   rd_a_data, rd_b_data, wr_data = '0;
  logic            wr_en = 1'b0, save_req = 1'b0, restore_req = 1'b0, wim_we = 1'b0;
  logic [NWIN-1:0] wim_wdata = '0;
  logic [4:0]      cwp_o;
  logic            ovf_trap, unf_trap;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [DW-1:0]   m_rf [NPHYS];
  int              m_cwp;
  logic [NWIN-1:0] m_wim;
  logic            e_ovf, e_unf;

  always #10 clk = ~clk;

  win_regfile #(.NWIN(NWIN), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .save_req(save_req), .restore_req(restore_req),
    .wim_we(wim_we), .wim_wdata(wim_wdata),
    .cwp_o(cwp_o), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
  );

  function automatic int pidx(int cw, int r);
    if (r < 8) return r;
    return 8 + ((cw * 16 + r - 8) % (NWIN * 16));
  endfunction

  function automatic logic [DW-1:0] exp_rd(int r);
    if (r == 0) return '0;
    if (wr_en && wr_addr != 0 && pidx(m_cwp, int'(wr_addr)) == pidx(m_cwp, r))
      return wr_data;
    return m_rf[pidx(m_cwp, r)];
  endfunction

  task automatic chk(string req, string what, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic cycle(bit we, int wa, logic [DW-1:0] wd, bit sv, bit rs,
                       bit mwe, logic [NWIN-1:0] mw, int ra, int rb, string tag);
    wr_en = we; wr_addr = 5'(wa); wr_data = wd;
    save_req = sv; restore_req = rs; wim_we = mwe; wim_wdata = mw;
    rd_a_addr = 5'(ra); rd_b_addr = 5'(rb);
    #5;
    chk(tag, "read A", rd_a_data, exp_rd(ra));
    chk(tag, "read B", rd_b_data, exp_rd(rb));
    @(posedge clk);
    if (we && wa != 0) m_rf[pidx(m_cwp, wa)] = wd;
    e_ovf = 1'b0; e_unf = 1'b0;
    if (sv) begin
      int t = (m_cwp + NWIN - 1) % NWIN;
      if (m_wim[t]) e_ovf = 1'b1; else m_cwp = t;
    end else if (rs) begin
      int t = (m_cwp + 1) % NWIN;
      if (m_wim[t]) e_unf = 1'b1; else m_cwp = t;
    end
    if (mwe) m_wim = mw;
    @(negedge clk);
    chk("R5", "cwp", DW'(cwp_o), DW'(m_cwp));
    chk("R6", "ovf_trap", DW'(ovf_trap), DW'(e_ovf));
    chk("R6", "unf_trap", DW'(unf_trap), DW'(e_unf));
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NPHYS; i++) m_rf[i] = '0;
    m_cwp = 0; m_wim = '0; e_ovf = 1'b0; e_unf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R4: reset state
    chk("R4", "cwp after reset", DW'(cwp_o), '0);
    chk("R4", "ovf after reset", DW'(ovf_trap), '0);
    cycle(0, 0, '0, 0, 0, 0, '0, 5, 20, "R4");
    // R2: zero register, same cycle and later
    cycle(1, 0, 32'hDEAD_BEEF, 0, 0, 0, '0, 0, 0, "R2");
    cycle(0, 0, '0, 0, 0, 0, '0, 0, 0, "R2");
    // R8: write outgoing reg with a save; R3: seen as incoming reg of new window
    cycle(1, 12, 32'h1111_1111, 1, 0, 0, '0, 12, 28, "R8");
    cycle(0, 0, '0, 0, 0, 0, '0, 28, 12, "R3");
    // R4: local of window 7, restore, local of window 0 untouched
    cycle(1, 20, 32'h2222_2222, 0, 1, 0, '0, 20, 0, "R4");
    cycle(0, 0, '0, 0, 0, 0, '0, 20, 12, "R4");
    // R7: same-cycle bypass on both ports
    cycle(1, 9, 32'h3333_3333, 0, 0, 0, '0, 9, 9, "R7");
    // R1: global across windows
    cycle(1, 2, 32'h4444_4444, 1, 0, 0, '0, 2, 0, "R1");
    cycle(0, 0, '0, 0, 0, 0, '0, 2, 25, "R1");
    // R3: wrap at top window, ins of window 7 are outs of window 0
    cycle(0, 0, '0, 0, 0, 0, '0, 28, 25, "R3");
    // R5: restore wraps 7 -> 0, both requests: save wins
    cycle(0, 0, '0, 0, 1, 0, '0, 0, 0, "R5");
    cycle(0, 0, '0, 1, 1, 0, '0, 0, 0, "R5");
    cycle(0, 0, '0, 0, 1, 0, '0, 0, 0, "R5");
    // R6: mask windows 1 and 7, from window 0 both directions blocked
    cycle(0, 0, '0, 0, 0, 1, 8'h82, 0, 0, "R6");
    cycle(0, 0, '0, 0, 1, 0, '0, 0, 0, "R6");
    cycle(0, 0, '0, 1, 0, 0, '0, 0, 0, "R6");
    cycle(0, 0, '0, 1, 1, 0, '0, 0, 0, "R6");
    cycle(0, 0, '0, 0, 0, 1, '0, 0, 0, "R6");

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      bit              we  = ($urandom % 4) != 0;
      int              wa  = $urandom % 32;
      logic [DW-1:0]   wd  = $urandom;
      int              op  = $urandom % 8;
      bit              mwe = ($urandom % 40) == 0;
      logic [NWIN-1:0] mw  = NWIN'($urandom) & NWIN'($urandom) & NWIN'($urandom);
      int              ra  = $urandom % 32;
      int              rb  = (n % 3 == 0) ? wa : int'($urandom % 32);
      cycle(we, wa, wd, op == 0, op == 1 || op == 2, mwe, mw, ra, rb,
            (ra < 8) ? "R1" : "R3");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule